// File: doc/BRIEF.md
# Dual Half-Word Signed Multiply-Accumulate

This block treats each of two 32-bit operands as a pair of signed 16-bit halves and multiplies them lane by lane. The low-half product and the high-half product are then combined, by addition or by subtraction. An optional 32-bit signed accumulator can be folded into that result. The outcome goes into a result register. A sticky overflow flag records every signed overflow that the selected arithmetic produces. Operations can set the flag but never clear it; only a dedicated clear input resets it.

A swap control exchanges the two halves of operand B before the multiply, so that cross products can be formed. The result is never clamped: it always wraps modulo 2^32, and the flag alone reports that the true value fell outside the signed 32-bit range. When both products are added to the accumulator, overflow is judged once, from the exact three-term sum. An intermediate pair sum that overflows on its own therefore does not set the flag if the accumulator brings the total back into range.

Top module: `dmac_unit`

## Requirements
- R1: Bits [15:0] of each operand form the low signed half and bits [31:16] form the high signed half. The unit forms low(A)·low(B) as the first product and high(A)·high(B) as the second, each as an exact signed 32-bit value.
- R2: When `swap_i` is 1, the halves of B are exchanged before the multiply. The first product becomes low(A)·high(B) and the second becomes high(A)·low(B).
- R3: With `sub_i`=1 and `acc_en_i`=0, the result is first minus second, using plain 32-bit arithmetic, and the flag is never set.
- R4: With `sub_i`=1 and `acc_en_i`=1, the result is (first − second) + `acc_i`. The flag is set when that 32-bit signed addition overflows.
- R5: With `sub_i`=0 and `acc_en_i`=0, the result is first + second. The flag is set when that signed 32-bit addition overflows.
- R6: With `sub_i`=0 and `acc_en_i`=1, the result is the low 32 bits of the exact sum of both products and `acc_i`. The flag is set only when that exact sum lies outside [−2^31, 2^31−1]. For example, two (−32768·−32768) products plus −1 gives 0x7FFFFFFF and does not set the flag.
- R7: On overflow the result wraps modulo 2^32 and is never clamped.
- R8: When `acc_en_i`=0, the value on `acc_i` has no effect on the result or the flag.
- R9: An operation may set `ovf_o` but never clears it. A non-overflowing operation leaves the flag unchanged.
- R10: When `clr_i`=1 at a rising clock edge, `ovf_o` becomes 0, even if an overflowing operation is accepted in the same cycle. The result register still updates from that operation.
- R11: `res_o` and `ovf_o` change only on a rising edge where `vld_i`=1 (or `clr_i`=1, for the flag). Otherwise both hold their values.
- R12: An active-low asynchronous reset sets `res_o` to 0 and `ovf_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Accept the operation presented this cycle |
| acc_en_i | input | 1 | Fold the accumulator into the result |
| swap_i | input | 1 | Exchange the halves of operand B before multiplying |
| sub_i | input | 1 | Subtract the second product instead of adding it |
| clr_i | input | 1 | Synchronous clear of the sticky flag |
| op_a_i | input | 32 | Operand A, two signed 16-bit halves |
| op_b_i | input | 32 | Operand B, two signed 16-bit halves |
| acc_i | input | 32 | Signed accumulator value |
| res_o | output | 32 | Registered result, wraps modulo 2^32 |
| ovf_o | output | 1 | Sticky signed-overflow flag |

## Verification
Two events can meet at the same clock edge: the flag clear, and the acceptance of an operation that overflows. The bench drives `clr_i` and `vld_i` high together, with both halves of each operand at −32768 in the add mode without the accumulator. After that edge, the flag must read 0 and the result must read the wrapped 0x80000000. A separate case sets the flag first and then issues a clean operation with no clear. Here the flag must stay at 1 while the result changes, which separates stickiness from the clear priority.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    // Arithmetic path selected by the subtract and accumulate controls
    typedef enum logic [1:0] {
        MODE_DIFF     = 2'd0,
        MODE_DIFF_ACC = 2'd1,
        MODE_SUM      = 2'd2,
        MODE_SUM_ACC  = 2'd3
    } dmac_mode_e;

    function automatic dmac_mode_e dmac_pick_mode(input logic sub, input logic acc_en);
        dmac_mode_e m;
        case ({sub, acc_en})
            2'b10:   m = MODE_DIFF;
            2'b11:   m = MODE_DIFF_ACC;
            2'b00:   m = MODE_SUM;
            default: m = MODE_SUM_ACC;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dmac_halfmul.sv
module dmac_halfmul #(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] a_i,
    input  logic [2*HALF_W-1:0] b_i,
    input  logic                swap_i,
    output logic [2*HALF_W-1:0] prod_first_o,
    output logic [2*HALF_W-1:0] prod_second_o
);
    localparam int W = 2 * HALF_W;

    logic [W-1:0] b_eff;
    logic [W-1:0] prods [2];

    // Swap exchanges the halves of the second operand
    always_comb begin
        if (swap_i) b_eff = {b_i[HALF_W-1:0], b_i[W-1:HALF_W]};
        else        b_eff = b_i;
    end

    // One signed lane multiplier per half
    for (genvar lane = 0; lane < 2; lane++) begin : g_lane
        logic [HALF_W-1:0] ah;
        logic [HALF_W-1:0] bh;
        logic [W-1:0]      ax;
        logic [W-1:0]      bx;
        always_comb begin
            ah = a_i[lane*HALF_W +: HALF_W];
            bh = b_eff[lane*HALF_W +: HALF_W];
            ax = {{HALF_W{ah[HALF_W-1]}}, ah};
            bx = {{HALF_W{bh[HALF_W-1]}}, bh};
            // Product of sign-extended values is exact in W bits
            prods[lane] = ax * bx;
        end
    end

    assign prod_first_o  = prods[0];
    assign prod_second_o = prods[1];

endmodule

// File: rtl/dmac_combine.sv
module dmac_combine
    import dmac_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] prod_first_i,
    input  logic [WORD_W-1:0] prod_second_i,
    input  logic [WORD_W-1:0] acc_i,
    input  dmac_mode_e        mode_i,
    output logic [WORD_W-1:0] res_o,
    output logic              ovf_hit_o
);
    localparam int WIDE_W = 2 * WORD_W;
    localparam int MSB    = WORD_W - 1;

    logic [WORD_W-1:0] diff_w;
    logic [WORD_W-1:0] pair_w;
    logic [WORD_W-1:0] diff_acc_w;
    logic [WIDE_W-1:0] wide_sum;
    logic [WIDE_W-1:0] ext_first;
    logic [WIDE_W-1:0] ext_second;
    logic [WIDE_W-1:0] ext_acc;

    always_comb begin
        diff_w     = prod_first_i - prod_second_i;
        pair_w     = prod_first_i + prod_second_i;
        diff_acc_w = diff_w + acc_i;
        ext_first  = {{WORD_W{prod_first_i[MSB]}}, prod_first_i};
        ext_second = {{WORD_W{prod_second_i[MSB]}}, prod_second_i};
        ext_acc    = {{WORD_W{acc_i[MSB]}}, acc_i};
        wide_sum   = ext_first + ext_second + ext_acc;

        res_o     = diff_w;
        ovf_hit_o = 1'b0;
        case (mode_i)
            MODE_DIFF: begin
                res_o     = diff_w;
                ovf_hit_o = 1'b0;
            end
            MODE_DIFF_ACC: begin
                res_o     = diff_acc_w;
                ovf_hit_o = (diff_w[MSB] == acc_i[MSB]) && (diff_acc_w[MSB] != diff_w[MSB]);
            end
            MODE_SUM: begin
                res_o     = pair_w;
                ovf_hit_o = (prod_first_i[MSB] == prod_second_i[MSB])
                         && (pair_w[MSB] != prod_first_i[MSB]);
            end
            MODE_SUM_ACC: begin
                // Single decision from the exact three-term sum
                res_o     = wide_sum[WORD_W-1:0];
                ovf_hit_o = wide_sum[WIDE_W-1:WORD_W] != {WORD_W{wide_sum[MSB]}};
            end
            default: begin
                res_o     = diff_w;
                ovf_hit_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dmac_unit.sv
module dmac_unit
    import dmac_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic                acc_en_i,
    input  logic                swap_i,
    input  logic                sub_i,
    input  logic                clr_i,
    input  logic [2*HALF_W-1:0] op_a_i,
    input  logic [2*HALF_W-1:0] op_b_i,
    input  logic [2*HALF_W-1:0] acc_i,
    output logic [2*HALF_W-1:0] res_o,
    output logic                ovf_o
);
    localparam int W = 2 * HALF_W;

    typedef struct packed {
        logic [W-1:0] res;
        logic         ovf;
    } dmac_state_t;

    dmac_state_t st_d, st_q;

    logic [W-1:0] prod_first, prod_second;
    logic [W-1:0] comb_res;
    logic         comb_hit;
    dmac_mode_e   mode;

    assign mode = dmac_pick_mode(sub_i, acc_en_i);

    dmac_halfmul #(.HALF_W(HALF_W)) u_mul (
        .a_i          (op_a_i),
        .b_i          (op_b_i),
        .swap_i       (swap_i),
        .prod_first_o (prod_first),
        .prod_second_o(prod_second)
    );

    dmac_combine #(.WORD_W(W)) u_comb (
        .prod_first_i (prod_first),
        .prod_second_i(prod_second),
        .acc_i        (acc_i),
        .mode_i       (mode),
        .res_o        (comb_res),
        .ovf_hit_o    (comb_hit)
    );

    always_comb begin
        st_d = st_q;
        if (vld_i) begin
            st_d.res = comb_res;
            st_d.ovf = st_q.ovf | comb_hit;
        end
        if (clr_i) st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o = st_q.res;
    assign ovf_o = st_q.ovf;

    // Plain difference never raises a clear flag
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && sub_i && !acc_en_i && !clr_i && !ovf_o) |=> !ovf_o);

    // Flag is sticky until cleared
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o);

    // Clear wins over any same-cycle set
    p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !ovf_o);

    // Result holds without an accepted operation
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(res_o));

    // Flag only rises from an accepted operation
    p_rise_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(vld_i));

endmodule

// File: tb/sim_dmac_unit.sv
module sim_dmac_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld_i = 1'b0, acc_en_i = 1'b0, swap_i = 1'b0, sub_i = 1'b0, clr_i = 1'b0;
    logic [31:0] op_a_i = '0, op_b_i = '0, acc_i = '0;
    logic [31:0] res_o;
    logic        ovf_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dmac_unit u0 (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .acc_en_i(acc_en_i),
        .swap_i(swap_i), .sub_i(sub_i), .clr_i(clr_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i), .acc_i(acc_i),
        .res_o(res_o), .ovf_o(ovf_o)
    );

    // {a, b, acc, acc_en, swap, sub, expected flag}
    localparam int NV = 15;
    localparam logic [99:0] VEC [NV] = '{
        {32'h0003_0002, 32'h0005_0004, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0},
        {32'h0003_0002, 32'h0005_0004, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0},
        {32'h0003_0002, 32'h0005_0004, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0},
        {32'h8000_8000, 32'h8000_8000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1},
        {32'h8000_8000, 32'h8000_8000, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0},
        {32'h8000_8000, 32'h8000_8000, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b1},
        {32'h8000_8000, 32'h8000_8000, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0},
        {32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b1},
        {32'h7FFF_8000, 32'h8000_8000, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0},
        {32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b1},
        {32'h8000_8000, 32'h7FFF_7FFF, 32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b1},
        {32'h8000_8000, 32'h7FFF_7FFF, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0},
        {32'h8000_8000, 32'h8000_8000, 32'hFFFF_FF9C, 1'b1, 1'b0, 1'b0, 1'b0},
        {32'h0002_0003, 32'h0007_0005, 32'h0000_0064, 1'b1, 1'b1, 1'b1, 1'b0},
        {32'h0001_0001, 32'h0001_0001, 32'h1234_5678, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0:  return "R1";
            1:  return "R2";
            2:  return "R3";
            3:  return "R5 R7";
            4:  return "R6";
            5:  return "R6 R7";
            6:  return "R4";
            7:  return "R4 R7";
            8:  return "R3";
            9:  return "R6";
            10: return "R6 R7";
            11: return "R5";
            12: return "R6";
            13: return "R2 R4";
            default: return "R8";
        endcase
    endfunction

    // 64-bit reference built from the requirements
    function automatic logic [31:0] ref_res(input logic [31:0] a, input logic [31:0] b,
                                            input logic [31:0] acc, input logic acc_en,
                                            input logic swap, input logic sub);
        logic [31:0] bb;
        longint p0, p1, s;
        bb = swap ? {b[15:0], b[31:16]} : b;
        p0 = longint'($signed(a[15:0])) * longint'($signed(bb[15:0]));
        p1 = longint'($signed(a[31:16])) * longint'($signed(bb[31:16]));
        s  = sub ? (p0 - p1) : (p0 + p1);
        if (acc_en) s = s + longint'($signed(acc));
        return s[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [99:0] v);
        op_a_i   = v[99:68];
        op_b_i   = v[67:36];
        acc_i    = v[35:4];
        acc_en_i = v[3];
        swap_i   = v[2];
        sub_i    = v[1];
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] exp_r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12 result at reset", res_o, 32'h0);
        check("R12 flag at reset", {31'h0, ovf_o}, 32'h0);
        rst_n = 1'b1;

        // Table walk: clear flag, then one accepted operation
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            clr_i = 1'b1;
            @(negedge clk);
            clr_i = 1'b0;
            drive(VEC[i]);
            vld_i = 1'b1;
            @(negedge clk);
            vld_i = 1'b0;
            exp_r = ref_res(VEC[i][99:68], VEC[i][67:36], VEC[i][35:4],
                            VEC[i][3], VEC[i][2], VEC[i][1]);
            check({vec_tag(i), " result"}, res_o, exp_r);
            check({vec_tag(i), " flag"}, {31'h0, ovf_o}, {31'h0, VEC[i][0]});
        end

        // R9: overflow, then a clean operation keeps the flag
        @(negedge clk);
        drive(VEC[3]);
        vld_i = 1'b1;
        @(negedge clk);
        drive(VEC[0]);
        @(negedge clk);
        vld_i = 1'b0;
        check("R9 result updated", res_o, 32'h0000_0017);
        check("R9 flag sticky", {31'h0, ovf_o}, 32'h1);

        // R11: inputs move without valid, state holds
        drive(VEC[10]);
        @(negedge clk);
        @(negedge clk);
        check("R11 result held", res_o, 32'h0000_0017);
        check("R11 flag held", {31'h0, ovf_o}, 32'h1);

        // R10: clear alone drops the flag, result held
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        check("R10 flag cleared", {31'h0, ovf_o}, 32'h0);
        check("R10 result held on clear", res_o, 32'h0000_0017);

        // R10: clear and overflowing operation in the same cycle
        drive(VEC[3]);
        vld_i = 1'b1;
        clr_i = 1'b1;
        @(negedge clk);
        vld_i = 1'b0;
        clr_i = 1'b0;
        check("R10 clear beats set", {31'h0, ovf_o}, 32'h0);
        check("R10 R7 result still wraps", res_o, 32'h8000_0000);

        // R8: accumulator value ignored when not enabled
        drive(VEC[14]);
        acc_i = 32'h7FFF_FFFF;
        vld_i = 1'b1;
        @(negedge clk);
        vld_i = 1'b0;
        check("R8 acc ignored result", res_o, 32'h0000_0002);
        check("R8 acc ignored flag", {31'h0, ovf_o}, 32'h0);

        // R12: reset mid-run
        rst_n = 1'b0;
        #3;
        check("R12 async reset result", res_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule